// File: doc/BRIEF.md
# Dual-ADC Nibble-Multiplexed Receive Interface

This block carries samples from a pair of 8-bit I/Q converters and one intermediate-frequency (IF) converter onto a narrow receive bus. All of its outputs are registered on the rising edge of the master clock. A free-running four-phase counter sets the frame. Each I/Q symbol leaves the block as four 4-bit packages over four cycles. The I word goes out before the Q word, and the upper half of each word goes out before its lower half. A sync strobe flags the first package of every symbol.

The IF converter has its own 12-bit output field, which is reloaded every second cycle. The IF output runs in lock with the I/Q frame, so every other IF reload falls on the symbol-start cycle. Samples arrive with valid strobes and are staged, with the most recent one kept. At each frame start the I/Q pair is copied into a holding register, so the four packages of a symbol always come from a single sample pair.

When the I/Q path is powered down, the nibble bus is quiet and sync stays low, while the IF output carries on as before. The IF converter can run at 10-bit or 12-bit resolution. All samples are straight binary.

Top module: `rx_nibble_mux`

## Requirements
- R1: A synchronous active-high reset clears the nibble bus, the sync strobe and the IF output to zero. It also clears the staged and held samples. The first rising edge after reset is released is frame phase 0.
- R2: The frame phases 0, 1, 2 and 3 repeat forever. After the edge of each phase, the nibble bus carries the following: phase 0 gives I[7:4], phase 1 gives I[3:0], phase 2 gives Q[7:4] and phase 3 gives Q[3:0].
- R3: The sync strobe is high only in the cycle after a phase-0 edge (the I upper package), exactly once every four cycles.
- R4: On the phase-0 edge, the I/Q pair is taken from the sample presented with its valid strobe in that cycle, or else from the latest staged sample. Samples that arrive during phases 1 to 3 do not change the packages of the current symbol.
- R5: The IF output is reloaded on the phase-0 and phase-2 edges only. It holds its value across the edges in between.
- R6: In 12-bit mode (mode select = 1), the IF output after a reload equals the 12-bit sample, taken either from that cycle's valid strobe or from the latest staged IF sample.
- R7: In 10-bit mode (mode select = 0), the IF output after a reload carries the sample's bits [9:0] in output bits [11:2], with output bits [1:0] set to zero.
- R8: Whenever the I/Q path is active, each sync pulse coincides with a fresh IF value, which is every second IF reload.
- R9: While power-down is high at a phase edge, the nibble bus is zero after that edge and sync is low. The IF reloads continue unchanged.
- R10: When no new valid sample arrives, the next symbol repeats the last staged I/Q pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| iqValid | input | 1 | Qualifies iSample and qSample |
| iSample | input | 8 | I converter sample, straight binary |
| qSample | input | 8 | Q converter sample, straight binary |
| ifValid | input | 1 | Qualifies ifSample |
| ifSample | input | 12 | IF converter sample; bits [9:0] are used in 10-bit mode |
| ifMode12 | input | 1 | 1 selects 12-bit IF, 0 selects 10-bit IF |
| iqPowerDown | input | 1 | Silences the I/Q nibble path and its sync |
| rxNibble | output | 4 | Multiplexed I/Q nibble bus |
| rxSync | output | 1 | Symbol-start strobe |
| ifOut | output | 12 | IF output field |

## Verification
The assertions are checked on every cycle. They cover the following:
- the sync strobe never fires twice in a row, and each frame start comes with an IF reload;
- the held I/Q pair and the IF output change only on their load strobes;
- in 10-bit mode the low IF bits are zero after a reload;
- a power-down cycle leaves the nibble bus and sync quiet.

Some behaviours can only be shown by the bench's scenarios, because they need sample values followed across whole frames:
- the actual package order;
- the choice between a staged sample and a same-cycle sample at frame start;
- immunity to samples that arrive mid-frame;
- the repeating of a stale sample.

// File: rtl/rxmux_pkg.sv
package rxmux_pkg;
  localparam int PHASE_W = 2;

  typedef struct packed {
    logic [PHASE_W-1:0] phase;
    logic               frameStart;
    logic               ifLoad;
  } muxStrobes_t;
endpackage

// File: rtl/rxmux_ctrl.sv
module rxmux_ctrl
  import rxmux_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output muxStrobes_t strobes
);
  localparam int PHASES = 2 ** PHASE_W;

  logic [PHASE_W-1:0] phaseQ;

  always_ff @(posedge clk) begin
    if (rst) phaseQ <= '0;
    else if (phaseQ == PHASE_W'(PHASES - 1)) phaseQ <= '0;
    else phaseQ <= phaseQ + 1'b1;
  end

  always_comb begin
    strobes.phase      = phaseQ;
    strobes.frameStart = (phaseQ == '0);
    strobes.ifLoad     = ~phaseQ[0];
  end

  // R3
  frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.frameStart |=> !strobes.frameStart);

  // R8
  frame_if_align_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.frameStart |-> strobes.ifLoad);
endmodule

// File: rtl/rxmux_datapath.sv
module rxmux_datapath
  import rxmux_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int IF_W        = 12,
  parameter int IF_NARROW_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  muxStrobes_t         strobes,
  input  logic                iqValid,
  input  logic [SAMPLE_W-1:0] iSample,
  input  logic [SAMPLE_W-1:0] qSample,
  input  logic                ifValid,
  input  logic [IF_W-1:0]     ifSample,
  input  logic                ifMode12,
  input  logic                iqPowerDown,
  output logic [SAMPLE_W/2-1:0] rxNibble,
  output logic                rxSync,
  output logic [IF_W-1:0]     ifOut
);
  localparam int NIB_W = SAMPLE_W / 2;
  localparam int PAD_W = IF_W - IF_NARROW_W;

  logic [SAMPLE_W-1:0] stageI, stageQ, holdI, holdQ;
  logic [SAMPLE_W-1:0] newI, newQ;
  logic [IF_W-1:0]     stageIf, newIf, ifFmt;
  logic [NIB_W-1:0]    nibbleNext;

  // Same-cycle valid sample wins over the staged one
  always_comb begin
    newI  = iqValid ? iSample : stageI;
    newQ  = iqValid ? qSample : stageQ;
    newIf = ifValid ? ifSample : stageIf;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb ifFmt = ifMode12 ? newIf : {newIf[IF_NARROW_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      always_comb ifFmt = newIf;
    end
  endgenerate

  always_comb begin
    unique case (strobes.phase)
      2'd0:    nibbleNext = newI[SAMPLE_W-1:NIB_W];
      2'd1:    nibbleNext = holdI[NIB_W-1:0];
      2'd2:    nibbleNext = holdQ[SAMPLE_W-1:NIB_W];
      default: nibbleNext = holdQ[NIB_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stageI   <= '0;
      stageQ   <= '0;
      stageIf  <= '0;
      holdI    <= '0;
      holdQ    <= '0;
      rxNibble <= '0;
      rxSync   <= 1'b0;
      ifOut    <= '0;
    end else begin
      stageI  <= newI;
      stageQ  <= newQ;
      stageIf <= newIf;
      if (strobes.frameStart) begin
        holdI <= newI;
        holdQ <= newQ;
      end
      rxNibble <= iqPowerDown ? '0 : nibbleNext;
      rxSync   <= strobes.frameStart && !iqPowerDown;
      if (strobes.ifLoad) ifOut <= ifFmt;
    end
  end

  // R4
  hold_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.frameStart |=> $stable(holdI) && $stable(holdQ));

  // R5
  if_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.ifLoad |=> $stable(ifOut));

  // R7
  if_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.ifLoad && !ifMode12) |=> ifOut[PAD_W-1:0] == '0);

  // R9
  powerdown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    iqPowerDown |=> (rxNibble == '0) && !rxSync);
endmodule

// File: rtl/rx_nibble_mux.sv
module rx_nibble_mux #(
  parameter int SAMPLE_W    = 8,
  parameter int IF_W        = 12,
  parameter int IF_NARROW_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  iqValid,
  input  logic [SAMPLE_W-1:0]   iSample,
  input  logic [SAMPLE_W-1:0]   qSample,
  input  logic                  ifValid,
  input  logic [IF_W-1:0]       ifSample,
  input  logic                  ifMode12,
  input  logic                  iqPowerDown,
  output logic [SAMPLE_W/2-1:0] rxNibble,
  output logic                  rxSync,
  output logic [IF_W-1:0]       ifOut
);
  rxmux_pkg::muxStrobes_t strobes;

  rxmux_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes)
  );

  rxmux_datapath #(
    .SAMPLE_W    (SAMPLE_W),
    .IF_W        (IF_W),
    .IF_NARROW_W (IF_NARROW_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .iqValid     (iqValid),
    .iSample     (iSample),
    .qSample     (qSample),
    .ifValid     (ifValid),
    .ifSample    (ifSample),
    .ifMode12    (ifMode12),
    .iqPowerDown (iqPowerDown),
    .rxNibble    (rxNibble),
    .rxSync      (rxSync),
    .ifOut       (ifOut)
  );
endmodule

// File: tb/tb_rx_nibble_mux.sv
module tb_rx_nibble_mux;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iqValid = 1'b0;
  logic [7:0]  iSample = '0, qSample = '0;
  logic        ifValid = 1'b0;
  logic [11:0] ifSample = '0;
  logic        ifMode12 = 1'b1;
  logic        iqPowerDown = 1'b0;
  logic [3:0]  rxNibble;
  logic        rxSync;
  logic [11:0] ifOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Reference state, built from the requirements
  int          mPhase = 0;
  logic [7:0]  mStI = '0, mStQ = '0, mHoI = '0, mHoQ = '0;
  logic [11:0] mStIf = '0;
  logic [3:0]  eNib = '0;
  logic        eSync = 1'b0;
  logic [11:0] eIf = '0;

  always #2.5 clk = ~clk;

  rx_nibble_mux dut (
    .clk(clk), .rst(rst), .iqValid(iqValid), .iSample(iSample), .qSample(qSample),
    .ifValid(ifValid), .ifSample(ifSample), .ifMode12(ifMode12),
    .iqPowerDown(iqPowerDown), .rxNibble(rxNibble), .rxSync(rxSync), .ifOut(ifOut)
  );

  function automatic logic [11:0] fmtIf(input logic [11:0] s, input logic m12);
    return m12 ? s : {s[9:0], 2'b00};   // R6 / R7
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  // One clock: model the edge, then compare at the falling edge
  task automatic step();
    logic [7:0]  nI, nQ;
    logic [11:0] nIf;
    @(posedge clk);
    nI  = iqValid ? iSample : mStI;
    nQ  = iqValid ? qSample : mStQ;
    nIf = ifValid ? ifSample : mStIf;
    case (mPhase)
      0: begin mHoI = nI; mHoQ = nQ; eNib = nI[7:4]; end    // R2 R4 R10
      1: eNib = mHoI[3:0];
      2: eNib = mHoQ[7:4];
      default: eNib = mHoQ[3:0];
    endcase
    eSync = (mPhase == 0) && !iqPowerDown;                   // R3
    if (iqPowerDown) eNib = '0;                              // R9
    if (mPhase % 2 == 0) eIf = fmtIf(nIf, ifMode12);         // R5 R8
    mStI = nI; mStQ = nQ; mStIf = nIf;
    mPhase = (mPhase + 1) % 4;
    @(negedge clk);
    cycles++;
    chk(iqPowerDown ? "R9" : "R2", {28'd0, rxNibble}, {28'd0, eNib});
    chk("R3", {31'd0, rxSync}, {31'd0, eSync});
    chk(ifMode12 ? "R6" : "R7", {20'd0, ifOut}, {20'd0, eIf});
  endtask

  initial begin : watchdog
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", {28'd0, rxNibble}, 32'd0);
    chk("R1", {31'd0, rxSync}, 32'd0);
    chk("R1", {20'd0, ifOut}, 32'd0);
    rst = 1'b0;

    // R1: first edge is phase 0, staged samples zero -> nibble 0, sync 1
    step();
    chk("R1", {31'd0, rxSync}, 32'd1);

    // Directed: mid-frame sample change must not disturb the symbol (R4)
    iqValid = 1'b1; iSample = 8'hA5; qSample = 8'h3C; ifValid = 1'b1; ifSample = 12'hFFF;
    step(); step(); step();            // phases 1..3 stage A5/3C
    iqValid = 1'b0; ifValid = 1'b0;
    step();                            // phase 0: captures A5
    iqValid = 1'b1; iSample = 8'h00; qSample = 8'hFF;
    step();                            // phase 1 new sample mid-frame
    chk("R4", {28'd0, rxNibble}, 32'h5);
    iqValid = 1'b0;
    step(); chk("R4", {28'd0, rxNibble}, 32'h3);
    step(); chk("R4", {28'd0, rxNibble}, 32'hC);

    // R10: no valid -> next symbol repeats staged 00/FF
    repeat (4) step();

    // R7: 10-bit mode with all-ones sample keeps low bits zero
    ifMode12 = 1'b0; ifValid = 1'b1; ifSample = 12'hFFF;
    step(); step();
    chk("R7", {20'd0, ifOut}, 32'hFFC);
    ifValid = 1'b0;

    // R9: power-down silences I/Q while IF keeps reloading
    iqPowerDown = 1'b1;
    for (int k = 0; k < 8; k++) begin
      ifValid = 1'b1; ifSample = 12'(k * 37);
      step();
    end
    iqPowerDown = 1'b0; ifValid = 1'b0;

    // Random mix: valids, modes, occasional power-down (R2..R10)
    for (int n = 0; n < 3000; n++) begin
      iqValid     = ($urandom % 3) != 0;
      iSample     = 8'($urandom);
      qSample     = 8'($urandom);
      ifValid     = ($urandom % 2) == 0;
      ifSample    = 12'($urandom);
      if ($urandom % 64 == 0) ifMode12 = ~ifMode12;
      iqPowerDown = ($urandom % 16) == 0;
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule